// File: doc/BRIEF.md
# Integrating Vertical Sync Detector

This block finds the vertical interval in a sliced composite sync stream (active low) that has already been sampled into the clock domain. A saturating up/down counter stands in for an analog integrator. It climbs while sync is low and falls at a steeper rate while sync is high. Ordinary line sync pulses and equalizing pulses are too short to lift it to the threshold. The long broad pulses of the vertical interval do lift it there.

Crossing the threshold raises a vertical flag. The vertical output does not follow the broad pulses directly. A four-state machine opens the output on the rising edge that ends the first broad pulse, which is the start of the first serration. Once the flag has dropped, the machine closes the output on the rising edge that ends the second post-equalizing pulse. Both ends are tied to pulse edges, so the output width in half-lines stays fixed. It does not change with the field parity or with the number of pulses ahead of the vertical interval.

The states are IDLE, ARMED, ACTIVE and DRAIN. The transitions are:
- IDLE→ARMED when the flag is seen set.
- ARMED→ACTIVE on a sync rising edge while the integral is at or above the threshold.
- ARMED→IDLE on a sync rising edge with the integral below the threshold, or when the flag is seen clear.
- ACTIVE→DRAIN when the flag is seen clear.
- DRAIN→IDLE on the next sync rising edge.

The output is low in ACTIVE and in DRAIN.

Top module: `vsync_integrator`

## Requirements
- R1: A synchronous reset sets `vsync_n` high and `vflag` low on the clock edge that samples `rst` high.
- R2: A run of at least `THRESH` consecutive low samples of `csync_n` sets `vflag`. With the counter starting at zero, the flag becomes visible `THRESH`+1 edges after the first edge that samples the low level.
- R3: A run of fewer than `THRESH` low samples, starting from a zero count, never sets `vflag` and never drives `vsync_n` low.
- R4: The flag clears on the edge after the one that first samples `csync_n` high at the end of a low run, provided the count at that point is below `THRESH`. It stays set through every rising edge at which the count is at or above `THRESH`.
- R5: `vsync_n` falls on the edge after the one that samples the rising edge ending the first broad pulse, that is, the first rising edge seen while the flag is set and the count is at or above `THRESH`.
- R6: After the flag has cleared, `vsync_n` rises on the edge after the one that samples the next rising edge of `csync_n`, which is the end of the second post-equalizing pulse.
- R7: In an interval of six broad half-line pulses followed by equalizing pulses, the vertical output lasts exactly 7 half-lines plus the equalizing pulse width, minus the broad pulse width. This holds for either field phase and for any number of pre-equalizing pulses.
- R8: On each edge the count rises by `UP_STEP` when the sampled sync is low and falls by `DOWN_STEP` when it is high. It saturates at `CNT_MAX` and at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| csync_n | input | 1 | Sliced composite sync, low during sync pulses |
| vsync_n | output | 1 | Vertical sync, low while the vertical interval is reported |
| vflag | output | 1 | Integrator threshold flag, brought out for debug |

## Verification
The bench sweeps isolated low pulses from one cycle up to one past the threshold. A design whose threshold compare is off by one would set the flag one length too early or too late. Whole vertical intervals are run with both field phases and with five to eight pre-equalizing pulses, and the output is compared every cycle against windows worked out from the pulse edges. An edge-counting error would stretch the output to the first post-equalizing pulse or past the second, and a wrong width would show at once. A long low pulse followed by a short gap can only clear the flag if the counter saturated, so it catches a missing upper clamp or a wrong decay rate. A reset applied while the output is active must return both outputs to their inactive levels.

// File: rtl/vsd_pkg.sv
package vsd_pkg;

    typedef enum logic [1:0] {
        VS_IDLE   = 2'd0,
        VS_ARMED  = 2'd1,
        VS_ACTIVE = 2'd2,
        VS_DRAIN  = 2'd3
    } vs_state_t;

endpackage

// File: rtl/vsd_edge.sv
// Registers the sync input and marks its low-to-high transitions.
module vsd_edge (
    input  logic clk,
    input  logic rst,
    input  logic csync_n,
    output logic sync_lo,
    output logic rise
);

    logic cs_r;
    logic cs_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_r    <= 1'b1;
            cs_prev <= 1'b1;
        end else begin
            cs_r    <= csync_n;
            cs_prev <= cs_r;
        end
    end

    assign sync_lo = ~cs_r;
    assign rise    = cs_r & ~cs_prev;

endmodule

// File: rtl/vsd_integrator.sv
// Saturating up/down counter standing in for the charge integrator,
// plus the threshold flag it drives.
module vsd_integrator #(
    parameter int CNT_MAX   = 1023,
    parameter int THRESH    = 300,
    parameter int UP_STEP   = 1,
    parameter int DOWN_STEP = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_lo,
    input  logic rise,
    output logic above,
    output logic vflag
);

    localparam int CNT_W = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] MAX_C  = CNT_W'(CNT_MAX);
    localparam logic [CNT_W-1:0] UP_C   = CNT_W'(UP_STEP);
    localparam logic [CNT_W-1:0] DN_C   = CNT_W'(DOWN_STEP);
    localparam logic [CNT_W-1:0] TH_C   = CNT_W'(THRESH);
    localparam logic [CNT_W-1:0] UP_LIM = MAX_C - UP_C;

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] inc_v;
    logic [CNT_W-1:0] dec_v;

    always_comb begin
        if (count_q >= UP_LIM) inc_v = MAX_C;
        else                   inc_v = count_q + UP_C;
    end

    generate
        if (DOWN_STEP >= CNT_MAX) begin : g_dump
            // one high sample always empties the counter
            assign dec_v = '0;
        end else begin : g_sub
            always_comb begin
                if (count_q > DN_C) dec_v = count_q - DN_C;
                else                dec_v = '0;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)          count_q <= '0;
        else if (sync_lo) count_q <= inc_v;
        else              count_q <= dec_v;
    end

    assign above = (count_q >= TH_C);

    // set wins over clear; clear is judged only at the end of a pulse
    always_ff @(posedge clk) begin
        if (rst)        vflag <= 1'b0;
        else if (above) vflag <= 1'b1;
        else if (rise)  vflag <= 1'b0;
    end

endmodule

// File: rtl/vsd_vert_fsm.sv
// Clocks the vertical output in and out on sync pulse edges.
module vsd_vert_fsm
    import vsd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic vflag,
    input  logic above,
    input  logic rise,
    output logic vsync_n
);

    vs_state_t state_q;
    vs_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            VS_IDLE: begin
                if (vflag) state_d = VS_ARMED;
            end
            VS_ARMED: begin
                if (rise && above)  state_d = VS_ACTIVE;
                else if (rise)      state_d = VS_IDLE;
                else if (!vflag)    state_d = VS_IDLE;
            end
            VS_ACTIVE: begin
                if (!vflag) state_d = VS_DRAIN;
            end
            VS_DRAIN: begin
                if (rise) state_d = VS_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= VS_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) vsync_n <= 1'b1;
        else     vsync_n <= !((state_d == VS_ACTIVE) || (state_d == VS_DRAIN));
    end

endmodule

// File: rtl/vsync_integrator.sv
module vsync_integrator #(
    parameter int CNT_MAX   = 1023,
    parameter int THRESH    = 300,
    parameter int UP_STEP   = 1,
    parameter int DOWN_STEP = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic csync_n,
    output logic vsync_n,
    output logic vflag
);

    logic sync_lo;
    logic rise;
    logic above;

    vsd_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .csync_n (csync_n),
        .sync_lo (sync_lo),
        .rise    (rise)
    );

    vsd_integrator #(
        .CNT_MAX   (CNT_MAX),
        .THRESH    (THRESH),
        .UP_STEP   (UP_STEP),
        .DOWN_STEP (DOWN_STEP)
    ) u_integ (
        .clk     (clk),
        .rst     (rst),
        .sync_lo (sync_lo),
        .rise    (rise),
        .above   (above),
        .vflag   (vflag)
    );

    vsd_vert_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .vflag   (vflag),
        .above   (above),
        .rise    (rise),
        .vsync_n (vsync_n)
    );

endmodule

// File: rtl/vsync_integrator_chk.sv
module vsync_integrator_chk (
    input logic clk,
    input logic rst,
    input logic csync_n,
    input logic vsync_n,
    input logic vflag
);

    // R1
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (vsync_n && !vflag));

    // R2: the flag rises only after the input was sampled low
    p_flag_set_low_r2: assert property (@(posedge clk) disable iff (rst)
        ($rose(vflag) && !$past(rst)) |-> !$past(csync_n, 3));

    // R4: the flag drops only at the end of a low pulse
    p_flag_clear_edge_r4: assert property (@(posedge clk) disable iff (rst)
        ($fell(vflag) && !$past(rst)) |-> ($past(csync_n, 2) && !$past(csync_n, 3)));

    // R5
    p_vs_open_edge_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(vsync_n) |-> ($past(vflag) && $past(csync_n, 2) && !$past(csync_n, 3)));

    // R6
    p_vs_close_edge_r6: assert property (@(posedge clk) disable iff (rst)
        ($rose(vsync_n) && !$past(rst)) |->
        (!$past(vflag) && $past(csync_n, 2) && !$past(csync_n, 3)));

endmodule

bind vsync_integrator vsync_integrator_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .csync_n (csync_n),
    .vsync_n (vsync_n),
    .vflag   (vflag)
);

// File: tb/vsync_integrator_test.sv
`timescale 1ns/1ps
module vsync_integrator_test;

    localparam int TH  = 12;
    localparam int MXC = 30;
    localparam int UPS = 1;
    localparam int DNS = 8;
    localparam int HL  = 32;   // half-line in clocks
    localparam int BRD = 27;   // broad pulse low time
    localparam int EQW = 3;    // equalizing pulse low time
    localparam int HSW = 5;    // line sync low time
    localparam int NONE = -100000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic csync_n = 1'b1;
    logic vsync_n;
    logic vflag;

    always #5 clk = ~clk;

    vsync_integrator #(
        .CNT_MAX(MXC), .THRESH(TH), .UP_STEP(UPS), .DOWN_STEP(DNS)
    ) uut (
        .clk(clk), .rst(rst), .csync_n(csync_n), .vsync_n(vsync_n), .vflag(vflag)
    );

    int n_chk = 0;
    int n_err = 0;
    int step = 0;
    int vf_in = NONE;
    int vr_in = NONE;
    int fs = NONE;
    int fc = NONE;
    bit chk_v = 1'b1;
    bit chk_f = 1'b0;
    int lowcnt = 0;
    bit fseen = 1'b0;
    string ctx = "";

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s [%s] step=%0d: actual=%0d expected=%0d",
                     req, what, ctx, step, act, exp);
        end
    endtask

    // sample at the falling edge, then drive the next input sample
    task automatic tick(input logic v);
        bit ev;
        bit ef;
        @(negedge clk);
        if (chk_v) begin
            ev = !((step >= vf_in + 2) && (step < vr_in + 2));
            check(vsync_n == ev, "R5/R6", "vsync_n", int'(vsync_n), int'(ev));
        end
        if (chk_f) begin
            ef = (step >= fs) && (step < fc);
            check(vflag == ef, "R2/R4", "vflag", int'(vflag), int'(ef));
        end
        if (!vsync_n) lowcnt++;
        if (vflag) fseen = 1'b1;
        csync_n = v;
        step++;
    endtask

    task automatic pulse(input int lo, input int hi);
        repeat (lo) tick(1'b0);
        repeat (hi) tick(1'b1);
    endtask

    task automatic lines(input int n);
        repeat (n) pulse(HSW, 2*HL - HSW);
    endtask

    task automatic frame(input int npre, input bit half);
        int bs;
        lines(3);
        if (half) pulse(HSW, HL - HSW);
        repeat (npre) pulse(EQW, HL - EQW);
        bs = step;
        vf_in = bs + BRD;
        vr_in = bs + 7*HL + EQW;
        fs = bs + TH + 2;
        fc = bs + 6*HL + EQW + 2;
        chk_f = 1'b1;
        lowcnt = 0;
        repeat (6) pulse(BRD, HL - BRD);
        repeat (6) pulse(EQW, HL - EQW);
        lines(3);
        // R7: fixed width in clocks
        check(lowcnt == 7*HL + EQW - BRD, "R7", "vsync low width", lowcnt, 7*HL + EQW - BRD);
        chk_f = 1'b0;
        vf_in = NONE; vr_in = NONE; fs = NONE; fc = NONE;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int s;
        repeat (4) @(negedge clk);
        ctx = "reset";
        check(vsync_n == 1'b1, "R1", "vsync_n after reset", int'(vsync_n), 1);
        check(vflag == 1'b0, "R1", "vflag after reset", int'(vflag), 0);
        rst = 1'b0;

        // R5 R6 R7 across field phase and pre-equalizing count
        ctx = "frame odd 6";  frame(6, 1'b0);
        ctx = "frame even 6"; frame(6, 1'b1);
        ctx = "frame odd 5";  frame(5, 1'b0);
        ctx = "frame even 7"; frame(7, 1'b1);
        ctx = "frame odd 8";  frame(8, 1'b0);

        // R2 R3: isolated low pulse sweep, vsync checked every cycle
        for (int len = 1; len <= TH + 1; len++) begin
            ctx = $sformatf("glitch %0d", len);
            fseen = 1'b0;
            pulse(len, 40);
            pulse(HSW, 2*HL - HSW);
            if (len < TH)
                check(fseen == 1'b0, "R3", "flag seen", int'(fseen), 0);
            else
                check(fseen == 1'b1, "R2", "flag seen", int'(fseen), 1);
            check(vflag == 1'b0, "R4", "flag after line sync", int'(vflag), 0);
        end

        // R8: saturated count decays by DNS per clock, then clears on a short pulse
        ctx = "R8 saturation";
        s = step;
        vf_in = s + 40;
        vr_in = s + 91;
        fs = s + TH + 2;
        fc = s + 48;
        chk_f = 1'b1;
        pulse(40, 3);
        pulse(EQW, 40);
        pulse(HSW, 2*HL - HSW);
        chk_f = 1'b0;
        vf_in = NONE; vr_in = NONE; fs = NONE; fc = NONE;

        // R1: reset while the output is active
        ctx = "reset mid interval";
        chk_v = 1'b0;
        lines(2);
        repeat (6) pulse(EQW, HL - EQW);
        repeat (3) pulse(BRD, HL - BRD);
        check(vsync_n == 1'b0, "R5", "active before reset", int'(vsync_n), 0);
        rst = 1'b1;
        tick(1'b1);
        tick(1'b1);
        tick(1'b1);
        check(vsync_n == 1'b1, "R1", "vsync_n mid reset", int'(vsync_n), 1);
        check(vflag == 1'b0, "R1", "vflag mid reset", int'(vflag), 0);
        rst = 1'b0;
        chk_v = 1'b1;
        ctx = "after reset";
        lines(4);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule